// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block sits next to a first-level cache and holds a short queue of cache lines that follow the most recent miss. The cache presents every lookup to the block in the same cycle it probes its own tag array. The block compares the lookup against the oldest line in its queue only. When the cache misses and that oldest line matches, the block returns the line on its fill port and immediately asks memory for the line that follows the youngest one it holds, so the queue stays full. Prefetched lines never enter the cache until a demand miss consumes them.

When the cache misses and the oldest line does not match, the block throws its queue away and starts a new stream at the line after the miss. Requests already sent to memory for the old stream cannot be recalled. Their responses are counted off and discarded as they return. Memory answers in request order, and each answer fills the oldest entry still waiting for data. A demand hit on an entry whose data has not yet come back stalls the lookup port. The line is forwarded on the fill port as soon as the response lands.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset the queue is empty: `lk_ready` is 1, `mem_req_valid` is 0 and `fill_valid` is 0.
- R2: An accepted miss at line X that does not match the head starts a stream. It requests lines X+1 up to X+DEPTH in ascending order. Each request byte address is the line number times LINE_BYTES, so its low log2(LINE_BYTES) bits are zero.
- R3: Once memory has caught up, the last line requested is exactly head + DEPTH - 1. The block never runs further ahead than that.
- R4: `lk_buf_hit` is combinational in the lookup cycle. It is 1 only when a stream exists and the lookup's line equals the head line. A match on any other queued line gives 0.
- R5: On a head match whose data is present, `fill_valid` is 1 in the next cycle for exactly one cycle. `fill_addr` is the head line's byte address and `fill_data` is the memory data of that line. The head then advances by one line.
- R6: Every line consumed from the head causes exactly one further request, for the line after the current tail, so requests stay strictly sequential within a stream.
- R7: A head match on an entry still waiting for memory holds `lk_ready` at 0 until the response arrives. The fill then appears in the cycle after the response, carrying that response's data.
- R8: A miss that does not match the head discards the whole queue. It produces no fill. Responses to requests issued before the discard are dropped and never reach the fill port.
- R9: A lookup with `lk_cache_hit`=1, or with `lk_valid`=0, produces no fill and leaves the queue unchanged.
- R10: Memory responses fill queue entries in request order. Every fill carries the data of its own line.
- R11: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged, and `lk_ready` is 0. Requests still outstanding, counting dropped ones, never exceed MAX_OUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup presented this cycle |
| lk_addr | input | AW | Lookup byte address |
| lk_cache_hit | input | 1 | Cache's own hit result for this lookup |
| lk_ready | output | 1 | Block can accept a lookup this cycle |
| lk_buf_hit | output | 1 | Lookup line equals the queue head |
| fill_valid | output | 1 | Line delivered to the cache |
| fill_addr | output | AW | Byte address of the delivered line |
| fill_data | output | DW | Payload of the delivered line |
| mem_req_valid | output | 1 | Line request toward memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Byte address of the requested line |
| mem_rsp_valid | input | 1 | Memory response, in request order |
| mem_rsp_data | input | DW | Response payload |

## Verification
The hardest situation to reach from the ports is a discard while requests of the old stream are still in flight, followed at once by a demand hit on the new head that must wait. Only then does a wrong drop count show up as wrong fill data. The bench uses a fixed-latency memory whose data is a function of the line number. It issues a cold miss, a non-sequential miss one cycle later and then the next sequential line, so stale responses return first and must be skipped. Sweeps over gaps between consecutive hits, with memory backpressure switched on and a start line near the top of the line space, cover the stall, forwarding and wrap-around cases.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic [1:0] {
    SPB_EMPTY  = 2'd0,
    SPB_STREAM = 2'd1,
    SPB_STALL  = 2'd2
  } spb_mode_e;
endpackage

// File: rtl/spb_line_store.sv
module spb_line_store #(
  parameter int DEPTH = 4,
  parameter int LW    = 26,
  parameter int DW    = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [LW-1:0] base_line_i,
  input  logic          app_en_i,
  input  logic [IW-1:0] app_idx_i,
  input  logic [LW-1:0] app_line_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [IW-1:0] hd_idx_i,
  input  logic [IW-1:0] iss_idx_i,
  output logic [LW-1:0] hd_line_o,
  output logic          hd_pend_o,
  output logic [DW-1:0] hd_data_o,
  output logic [LW-1:0] iss_line_o,
  output logic          iss_pend_o
);
  logic [LW-1:0] line_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [DEPTH-1:0] pend_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        line_q[i] <= '0;
        data_q[i] <= '0;
        pend_q[i] <= 1'b0;
      end else if (flush_i) begin
        line_q[i] <= base_line_i + LW'(i);
        pend_q[i] <= 1'b1;
      end else begin
        if (wr_en_i && wr_idx_i == IW'(i)) begin
          data_q[i] <= wr_data_i;
          pend_q[i] <= 1'b0;
        end
        if (app_en_i && app_idx_i == IW'(i)) begin
          line_q[i] <= app_line_i;
          pend_q[i] <= 1'b1;
        end
      end
    end
  end

  assign hd_line_o  = line_q[hd_idx_i];
  assign hd_pend_o  = pend_q[hd_idx_i];
  assign hd_data_o  = data_q[hd_idx_i];
  assign iss_line_o = line_q[iss_idx_i];
  assign iss_pend_o = pend_q[iss_idx_i];
endmodule

// File: rtl/spb_out_track.sv
module spb_out_track #(
  parameter int MAX_OUT = 8,
  localparam int OW     = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          req_fire_i,
  input  logic          rsp_fire_i,
  output logic          rsp_take_o,
  output logic [OW-1:0] infl_o,
  output logic          room_o
);
  logic [OW-1:0] drop_q, infl_q, total;

  assign total      = drop_q + infl_q;
  assign room_o     = total < OW'(MAX_OUT);
  assign rsp_take_o = rsp_fire_i && drop_q == '0;
  assign infl_o     = infl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_q <= '0;
      infl_q <= '0;
    end else if (flush_i) begin
      drop_q <= total + OW'(req_fire_i) - OW'(rsp_fire_i);
      infl_q <= '0;
    end else begin
      infl_q <= infl_q + OW'(req_fire_i) - OW'(rsp_take_o);
      drop_q <= drop_q - OW'(rsp_fire_i && drop_q != '0);
    end
  end

  AST_OUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    total <= OW'(MAX_OUT)); // R11
  AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire_i |-> total != '0); // R10
endmodule

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf
  import spb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH      = 4,
  parameter int MAX_OUT    = 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LW        = AW - OFF_W,
  localparam int IW        = $clog2(DEPTH),
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int OW        = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  input  logic          lk_cache_hit,
  output logic          lk_ready,
  output logic          lk_buf_hit,
  output logic          fill_valid,
  output logic [AW-1:0] fill_addr,
  output logic [DW-1:0] fill_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
    return a[AW-1:OFF_W];
  endfunction
  function automatic logic [AW-1:0] line_addr(input logic [LW-1:0] l);
    return {l, {OFF_W{1'b0}}};
  endfunction
  function automatic logic [LW-1:0] seq_line(input logic [LW-1:0] l, input int k);
    return l + LW'(k);
  endfunction

  spb_mode_e     mode_q;
  logic [IW-1:0] hd_q, iss_q, fill_q;
  logic [CW-1:0] nun_q;
  logic [LW-1:0] tl_q, fill_line_q;
  logic          fill_valid_q;
  logic [DW-1:0] fill_data_q;

  logic [LW-1:0] lk_line, hd_line, iss_line;
  logic          hd_pend, iss_pend;
  logic [DW-1:0] hd_data, head_word;
  logic          alloc, req_stuck, head_match;
  logic          ev_acc_miss, ev_hit, ev_flush, ev_pop, ev_stall;
  logic          head_fill_now, head_ready;
  logic          req_fire, rsp_take, room;
  logic [OW-1:0] trk_infl;

  assign lk_line       = line_of(lk_addr);
  assign alloc         = mode_q != SPB_EMPTY;
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign req_stuck     = mem_req_valid && !mem_req_ready;
  assign lk_ready      = mode_q != SPB_STALL && !req_stuck;
  assign head_match    = alloc && lk_line == hd_line;
  assign lk_buf_hit    = lk_valid && lk_ready && head_match;
  assign ev_acc_miss   = lk_valid && lk_ready && !lk_cache_hit;
  assign ev_hit        = ev_acc_miss && head_match;
  assign ev_flush      = ev_acc_miss && !head_match;
  assign head_fill_now = rsp_take && fill_q == hd_q;
  assign head_ready    = !hd_pend || head_fill_now;
  assign head_word     = hd_pend ? mem_rsp_data : hd_data;
  assign ev_pop        = (ev_hit || mode_q == SPB_STALL) && head_ready;
  assign ev_stall      = ev_hit && !head_ready;

  assign mem_req_valid = alloc && nun_q != '0 && room;
  assign mem_req_addr  = line_addr(iss_line);

  assign fill_valid = fill_valid_q;
  assign fill_addr  = line_addr(fill_line_q);
  assign fill_data  = fill_data_q;

  spb_line_store #(.DEPTH(DEPTH), .LW(LW), .DW(DW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (ev_flush),
    .base_line_i(seq_line(lk_line, 1)),
    .app_en_i   (ev_pop),
    .app_idx_i  (hd_q),
    .app_line_i (seq_line(tl_q, 1)),
    .wr_en_i    (rsp_take),
    .wr_idx_i   (fill_q),
    .wr_data_i  (mem_rsp_data),
    .hd_idx_i   (hd_q),
    .iss_idx_i  (iss_q),
    .hd_line_o  (hd_line),
    .hd_pend_o  (hd_pend),
    .hd_data_o  (hd_data),
    .iss_line_o (iss_line),
    .iss_pend_o (iss_pend)
  );

  spb_out_track #(.MAX_OUT(MAX_OUT)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (ev_flush),
    .req_fire_i(req_fire),
    .rsp_fire_i(mem_rsp_valid),
    .rsp_take_o(rsp_take),
    .infl_o    (trk_infl),
    .room_o    (room)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q       <= SPB_EMPTY;
      hd_q         <= '0;
      iss_q        <= '0;
      fill_q       <= '0;
      nun_q        <= '0;
      tl_q         <= '0;
      fill_valid_q <= 1'b0;
      fill_line_q  <= '0;
      fill_data_q  <= '0;
    end else begin
      fill_valid_q <= ev_pop;
      if (ev_pop) begin
        fill_line_q <= hd_line;
        fill_data_q <= head_word;
      end
      if (ev_flush) begin
        mode_q <= SPB_STREAM;
        hd_q   <= '0;
        iss_q  <= '0;
        fill_q <= '0;
        nun_q  <= CW'(DEPTH);
        tl_q   <= seq_line(lk_line, DEPTH);
      end else begin
        if (ev_stall)                             mode_q <= SPB_STALL;
        else if (mode_q == SPB_STALL && ev_pop)   mode_q <= SPB_STREAM;
        hd_q   <= hd_q + IW'(ev_pop);
        iss_q  <= iss_q + IW'(req_fire);
        fill_q <= fill_q + IW'(rsp_take);
        nun_q  <= nun_q + CW'(ev_pop) - CW'(req_fire);
        tl_q   <= seq_line(tl_q, int'(ev_pop));
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11
  AST_ISSUE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> iss_pend); // R2
  AST_DEPTH_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    int'(nun_q) + int'(trk_infl) <= DEPTH); // R3
  AST_STALL_HEAD_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == SPB_STALL |-> hd_pend); // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |=> trk_infl == '0); // R8
  AST_IGNORE_CACHE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_cache_hit && mode_q != SPB_STALL |=> !fill_valid); // R9
endmodule

// File: tb/stream_prefetch_buf_bench.sv
module stream_prefetch_buf_bench;
  localparam int AW = 32, DW = 64, LB = 64, DEPTH = 4, MAX_OUT = 8;
  localparam int OFFW = 6, LW = AW - OFFW, LAT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_cache_hit = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic lk_ready, lk_buf_hit, fill_valid, mem_req_valid;
  logic [AW-1:0] fill_addr, mem_req_addr;
  logic [DW-1:0] fill_data, mem_rsp_data;
  logic mem_req_ready, mem_rsp_valid;

  stream_prefetch_buf #(.AW(AW), .DW(DW), .LINE_BYTES(LB), .DEPTH(DEPTH), .MAX_OUT(MAX_OUT))
  u_stream_prefetch_buf (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_cache_hit(lk_cache_hit), .lk_ready(lk_ready), .lk_buf_hit(lk_buf_hit),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data));

  initial forever #4 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 1'b0, bp_on = 1'b0, alloc = 1'b0;
  logic [LW-1:0] head = '0, exp_req = '0, flush_base = '0;

  function automatic logic [DW-1:0] mdata(input logic [LW-1:0] l);
    return {6'h2A, l, 6'h15, ~l};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural in-order memory with fixed latency
  logic [LW-1:0] q_line [64];
  int q_due [64];
  int qh = 0, qt = 0, ncyc = 0;
  initial begin
    logic [LW-1:0] ln;
    bit prev_stuck;
    logic [AW-1:0] prev_addr;
    prev_stuck = 1'b0; prev_addr = '0;
    mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      ncyc++;
      if (rst_n) begin
        if (prev_stuck)
          chk(mem_req_valid && mem_req_addr == prev_addr, "R11 hold", mem_req_addr, prev_addr);
        prev_stuck = mem_req_valid && !mem_req_ready;
        prev_addr = mem_req_addr;
        if (mem_req_valid && mem_req_ready) begin
          ln = mem_req_addr[AW-1:OFFW];
          chk(mem_req_addr[OFFW-1:0] == '0, "R2 align", 64'(mem_req_addr), 64'(0));
          chk(ln == exp_req || ln == flush_base, "R6 order", 64'(ln), 64'(exp_req));
          exp_req = ln + 1'b1;
          q_line[qt % 64] = ln; q_due[qt % 64] = ncyc + LAT; qt++;
        end
      end
      @(posedge clk); #1;
      mem_rsp_valid = 1'b0;
      if (qh != qt && q_due[qh % 64] <= ncyc) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mdata(q_line[qh % 64]);
        qh++;
      end
      mem_req_ready = bp_on ? (ncyc % 3 != 1) : 1'b1;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cache miss at line ln; returns number of stalled cycles
  task automatic miss(input logic [LW-1:0] ln, output int stall);
    bit exp_hit;
    int n;
    stall = 0;
    while (!lk_ready) @(negedge clk);
    lk_valid = 1'b1; lk_cache_hit = 1'b0;
    lk_addr = {ln, OFFW'(ln[5:0] * 5)};
    #1;
    exp_hit = alloc && ln == head;
    chk(lk_buf_hit == exp_hit, "R4 head match", 64'(lk_buf_hit), 64'(exp_hit));
    if (!exp_hit) flush_base = ln + 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    if (exp_hit) begin
      n = 0;
      while (!fill_valid && n < 100) begin
        chk(lk_ready == 1'b0, "R7 stall holds ready low", 64'(lk_ready), 64'(0));
        n++;
        @(negedge clk);
      end
      stall = n;
      chk(fill_valid, "R5 fill valid", 64'(fill_valid), 64'(1));
      chk(fill_addr == {ln, 6'h0}, "R5 fill addr", 64'(fill_addr), 64'({ln, 6'h0}));
      chk(fill_data == mdata(ln), "R10 fill data", fill_data, mdata(ln));
      @(negedge clk);
      chk(!fill_valid, "R5 single pulse", 64'(fill_valid), 64'(0));
      head = ln + 1'b1;
    end else begin
      chk(!fill_valid, "R8 no fill on discard", 64'(fill_valid), 64'(0));
      alloc = 1'b1;
      head = ln + 1'b1;
    end
  endtask

  task automatic settle();
    idle(30);
    chk(exp_req == head + LW'(DEPTH), "R3 run-ahead", 64'(exp_req), 64'(head + LW'(DEPTH)));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int st;
    logic [LW-1:0] starts [3];
    idle(4);
    rst_n = 1'b1;
    idle(1);
    chk(lk_ready, "R1 ready", 64'(lk_ready), 64'(1));
    chk(!mem_req_valid, "R1 no request", 64'(mem_req_valid), 64'(0));
    chk(!fill_valid, "R1 no fill", 64'(fill_valid), 64'(0));
    idle(3);
    chk(!mem_req_valid, "R1 idle quiet", 64'(mem_req_valid), 64'(0));

    // cold allocation and sequential consumption (R2, R3, R5, R6)
    miss(26'h100, st);
    settle();
    for (int i = 1; i <= 6; i++) miss(26'h100 + LW'(i), st);
    settle();

    // a match on the second entry is not a head hit (R4, R8)
    miss(head + 1'b1, st);
    settle();

    // hit before data has returned (R7)
    miss(26'h2000, st);
    miss(26'h2001, st);
    chk(st > 0, "R7 pending head stalls", 64'(st), 64'(1));
    settle();

    // discard with old requests in flight, then wait on new head (R8, R10)
    miss(26'h3000, st);
    miss(26'h5000, st);
    miss(26'h5001, st);
    chk(st > 0, "R8 stale responses skipped", 64'(st), 64'(1));
    settle();

    // cache-hit lookups and idle cycles are ignored (R9)
    @(negedge clk);
    lk_valid = 1'b1; lk_cache_hit = 1'b1; lk_addr = {head, 6'h0};
    @(negedge clk);
    lk_valid = 1'b0; lk_cache_hit = 1'b0;
    chk(!fill_valid, "R9 cache hit no fill", 64'(fill_valid), 64'(0));
    @(negedge clk);
    chk(!fill_valid, "R9 cache hit no fill later", 64'(fill_valid), 64'(0));
    settle();
    miss(head, st);
    settle();

    // sweep: start lines incl. wrap, gaps, with backpressure (R5, R6, R7, R11)
    starts[0] = 26'h0040; starts[1] = 26'h3FFFFFE; starts[2] = 26'h1234;
    for (int bp = 0; bp < 2; bp++) begin
      bp_on = bit'(bp);
      for (int s = 0; s < 3; s++) begin
        for (int gap = 0; gap <= LAT + 2; gap++) begin
          miss(starts[s] + LW'(gap * 64), st);
          for (int k = 0; k < 2 * DEPTH; k++) begin
            miss(head, st);
            idle(gap);
          end
        end
        settle();
      end
    end
    bp_on = 1'b0;
    settle();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule